// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative store of recent virtual-to-physical page translations, placed in front of a page table walker. A lookup presents a 27-bit virtual page number, the 12-bit page offset and the current 16-bit address space identifier. In the same cycle, the block returns a hit flag, the composed 56-bit physical address and the R/W/X/U permission bits of the matching entry. The ASID is the field held in bits [59:44] of the translation control register. On a miss, the walker walks the page tables and installs its result through the refill port.

Each entry carries its own ASID and a global flag. Because of this, changing the current ASID leaves the stored entries in place, and no full invalidation is needed on a context switch. An entry can map a 4KiB page, a 2MiB page or a 1GiB page. A larger page compares fewer virtual page number fields, and the fields it does not compare pass straight into the physical address. The flush port clears every entry, or only the non-global entries of one ASID.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, and `lk_pa` and `lk_perm` read zero.
- R2: A lookup that matches a 4KiB entry (level code 0) returns `lk_hit`=1 in the same cycle, with `lk_pa` = {stored PPN, `lk_off`} and the stored permissions. The permission encoding is bit0 R, bit1 W, bit2 X, bit3 U. A VPN that differs in any field misses.
- R3: A non-global entry matches only when its ASID equals `cur_asid`. Changing `cur_asid` does not invalidate entries, so switching back to the original ASID hits again.
- R4: An entry whose global flag is set matches under any `cur_asid`.
- R5: A 2MiB entry (level code 1) compares only VPN[26:18] and VPN[17:9]. Physical address bits [20:12] come from `lk_vpn[8:0]`.
- R6: A 1GiB entry (level code 2 or 3) compares only VPN[26:18]. Physical address bits [29:12] come from `lk_vpn[17:0]`.
- R7: On a miss, `lk_pa` and `lk_perm` are zero.
- R8: A refill writes the lowest-index invalid entry if one exists. Otherwise it overwrites the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on every refill that overwrites a valid entry. A refilled translation hits from the next cycle.
- R9: Asserting `fl_all` invalidates every entry at the next clock edge.
- R10: An ASID flush invalidates the non-global entries whose ASID equals `fl_asid`. Global entries and entries of other ASIDs survive.
- R11: When several entries match, the lowest-index entry supplies the address and permissions.
- R12: A refill in the same cycle as a flush is kept. The flush does not remove the entry just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 27 | Lookup virtual page number {VPN2, VPN1, VPN0} |
| lk_off | input | 12 | Lookup page offset |
| cur_asid | input | 16 | Current address space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 56 | Composed physical address (zero on miss) |
| lk_perm | output | 4 | Permissions {U, X, W, R} (zero on miss) |
| rf_en | input | 1 | Refill strobe |
| rf_vpn | input | 27 | Refill virtual page number |
| rf_asid | input | 16 | Refill ASID |
| rf_ppn | input | 44 | Refill leaf physical page number |
| rf_lvl | input | 2 | Refill page size: 0 4KiB, 1 2MiB, 2 or 3 1GiB |
| rf_glb | input | 1 | Refill global flag |
| rf_perm | input | 4 | Refill permissions {U, X, W, R} |
| fl_all | input | 1 | Invalidate all entries |
| fl_asid_en | input | 1 | Invalidate non-global entries of `fl_asid` |
| fl_asid | input | 16 | ASID selected for a selective flush |

## Verification
Four behaviours are checked on every cycle by the assertions. A miss always drives zero onto the address and permission outputs. A hit always carries the lookup offset through to the low address bits. A translation just refilled is visible to a matching lookup in the next cycle. A full flush leaves nothing to hit. The bench scenarios cover the rest: the ASID filtering and global matching, the superpage field pass-through, the lowest-index choice between overlapping entries, the order of round-robin eviction, the selective flush, and a refill that collides with a flush. Each of these depends on a history of refills and on exact expected addresses.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 16,
  parameter int PPN_W   = 44,
  parameter int FLD_W   = 9,
  parameter int OFF_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3*FLD_W-1:0]      lk_vpn,
  input  logic [OFF_W-1:0]        lk_off,
  input  logic [ASID_W-1:0]       cur_asid,
  output logic                    lk_hit,
  output logic [PPN_W+OFF_W-1:0]  lk_pa,
  output logic [3:0]              lk_perm,
  input  logic                    rf_en,
  input  logic [3*FLD_W-1:0]      rf_vpn,
  input  logic [ASID_W-1:0]       rf_asid,
  input  logic [PPN_W-1:0]        rf_ppn,
  input  logic [1:0]              rf_lvl,
  input  logic                    rf_glb,
  input  logic [3:0]              rf_perm,
  input  logic                    fl_all,
  input  logic                    fl_asid_en,
  input  logic [ASID_W-1:0]       fl_asid
);
  localparam int VPN_W = 3*FLD_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] val_q, glb_q, hit_v;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [1:0]         lvl_q  [ENTRIES];
  logic [3:0]         perm_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, sel, free_idx, victim;
  logic               has_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic hi_eq, mid_eq, lo_eq;
    assign hi_eq  = vpn_q[g][VPN_W-1 -: FLD_W] == lk_vpn[VPN_W-1 -: FLD_W];
    assign mid_eq = vpn_q[g][2*FLD_W-1 -: FLD_W] == lk_vpn[2*FLD_W-1 -: FLD_W];
    assign lo_eq  = vpn_q[g][FLD_W-1:0] == lk_vpn[FLD_W-1:0];
    assign hit_v[g] = val_q[g] && (glb_q[g] || asid_q[g] == cur_asid) && hi_eq
                      && (lvl_q[g][1] || mid_eq) && (lvl_q[g] != 2'd0 || lo_eq);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (hit_v[i]) sel = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!val_q[i]) free_idx = IDX_W'(i);
  end

  assign has_free = ~&val_q;
  assign victim   = has_free ? free_idx : rr_q;
  assign lk_hit   = |hit_v;

  always_comb begin
    lk_pa   = '0;
    lk_perm = '0;
    if (lk_hit) begin
      lk_pa = {ppn_q[sel][PPN_W-1:2*FLD_W],
               lvl_q[sel][1]       ? lk_vpn[2*FLD_W-1 -: FLD_W] : ppn_q[sel][2*FLD_W-1 -: FLD_W],
               lvl_q[sel] != 2'd0  ? lk_vpn[FLD_W-1:0]          : ppn_q[sel][FLD_W-1:0],
               lk_off};
      lk_perm = perm_q[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      glb_q <= '0;
      rr_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (fl_all || (fl_asid_en && !glb_q[i] && asid_q[i] == fl_asid))
          val_q[i] <= 1'b0;
      if (rf_en) begin
        val_q[victim] <= 1'b1;
        glb_q[victim] <= rf_glb;
        if (!has_free)
          rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rf_en) begin
      asid_q[victim] <= rf_asid;
      vpn_q[victim]  <= rf_vpn;
      ppn_q[victim]  <= rf_ppn;
      lvl_q[victim]  <= rf_lvl;
      perm_q[victim] <= rf_perm;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ASID_W = 16,
  parameter int PPN_W  = 44,
  parameter int FLD_W  = 9,
  parameter int OFF_W  = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3*FLD_W-1:0]     lk_vpn,
  input logic [OFF_W-1:0]       lk_off,
  input logic [ASID_W-1:0]      cur_asid,
  input logic                   lk_hit,
  input logic [PPN_W+OFF_W-1:0] lk_pa,
  input logic [3:0]             lk_perm,
  input logic                   rf_en,
  input logic [3*FLD_W-1:0]     rf_vpn,
  input logic [ASID_W-1:0]      rf_asid,
  input logic                   rf_glb,
  input logic                   fl_all
);
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && lk_perm == '0));

  a_r2_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_off);

  a_r8_refill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rf_en) && lk_vpn == $past(rf_vpn)
     && ($past(rf_glb) || cur_asid == $past(rf_asid))) |-> lk_hit);

  a_r9_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fl_all) && !$past(rf_en)) |-> !lk_hit);
endmodule

bind asid_tlb asid_tlb_chk u_chk (.*);

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
  logic clk = 0, rst_n = 0;
  logic [26:0] lk_vpn = '0, rf_vpn = '0;
  logic [11:0] lk_off = '0;
  logic [15:0] cur_asid = '0, rf_asid = '0, fl_asid = '0;
  logic        lk_hit, rf_en = 0, rf_glb = 0, fl_all = 0, fl_asid_en = 0;
  logic [55:0] lk_pa;
  logic [3:0]  lk_perm, rf_perm = '0;
  logic [43:0] rf_ppn = '0;
  logic [1:0]  rf_lvl = '0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  asid_tlb u0 (.*);

  function automatic logic [26:0] vp(int a, int b, int c);
    logic [8:0] x = a[8:0], y = b[8:0], z = c[8:0];
    return {x, y, z};
  endfunction

  localparam logic [43:0] PA_ = 44'h123_4567_89AB;
  localparam logic [43:0] PB_ = 44'hABC_DEF0_1234;
  localparam logic [43:0] PC_ = 44'h0F0_F0F0_F0F0;
  localparam logic [43:0] PD_ = 44'h000_0000_0007;
  localparam logic [43:0] P1_ = 44'h111_2222_3333;
  localparam logic [43:0] P2_ = 44'h0AA_BBBB_CCCC;

  typedef struct packed {
    logic [7:0]  req;
    logic [26:0] vpn;
    logic [11:0] off;
    logic [15:0] asid;
    logic        hit;
    logic [55:0] pa;
    logic [3:0]  perm;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{8'd2, vp(1,2,3),       12'hABC, 16'd5,      1'b1, {PA_, 12'hABC}, 4'b0011},            // R2
    '{8'd3, vp(1,2,3),       12'hABC, 16'd6,      1'b0, 56'h0, 4'h0},                        // R3
    '{8'd3, vp(1,2,3),       12'h000, 16'd5,      1'b1, {PA_, 12'h000}, 4'b0011},            // R3
    '{8'd5, vp(4,9,9'h1FF),  12'h123, 16'd5,      1'b1, {PB_[43:9], 9'h1FF, 12'h123}, 4'b1100}, // R5
    '{8'd5, vp(4,10,1),      12'h123, 16'd5,      1'b0, 56'h0, 4'h0},                        // R5
    '{8'd6, vp(7,9'h55,9'h1AA), 12'hFFF, 16'd6,   1'b1, {PC_[43:18], 9'h055, 9'h1AA, 12'hFFF}, 4'b0001}, // R6
    '{8'd6, vp(6,9'h55,9'h1AA), 12'hFFF, 16'd6,   1'b0, 56'h0, 4'h0},                        // R6
    '{8'd4, vp(8,8,8),       12'h321, 16'h1234,   1'b1, {PD_, 12'h321}, 4'b0101},            // R4
    '{8'd7, vp(8,8,9),       12'h321, 16'd5,      1'b0, 56'h0, 4'h0},                        // R7
    '{8'd2, vp(1,2,4),       12'h000, 16'd5,      1'b0, 56'h0, 4'h0}                         // R2
  };

  task automatic chk(string r, logic h, logic [55:0] pa, logic [3:0] pm);
    n_chk++;
    if (lk_hit !== h || lk_pa !== pa || lk_perm !== pm) begin
      n_err++;
      $display("FAIL %s: hit=%b pa=%h perm=%h expected hit=%b pa=%h perm=%h",
               r, lk_hit, lk_pa, lk_perm, h, pa, pm);
    end
  endtask

  task automatic look(logic [26:0] v, logic [11:0] o, logic [15:0] a);
    @(negedge clk);
    lk_vpn = v; lk_off = o; cur_asid = a;
    #1;
  endtask

  task automatic refill(logic [26:0] v, logic [15:0] a, logic [43:0] p,
                        logic [1:0] l, logic g, logic [3:0] pm, logic fa = 0);
    @(negedge clk);
    rf_en = 1; rf_vpn = v; rf_asid = a; rf_ppn = p; rf_lvl = l; rf_glb = g; rf_perm = pm;
    fl_all = fa;
    @(negedge clk);
    rf_en = 0; fl_all = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(vp(1,2,3), 12'h5, 16'd5);
    chk("R1 reset empty", 0, 56'h0, 4'h0);

    refill(vp(1,2,3), 16'd5, PA_, 2'd0, 0, 4'b0011);
    refill(vp(4,9,0), 16'd5, PB_, 2'd1, 0, 4'b1100);
    refill(vp(7,0,0), 16'd6, PC_, 2'd2, 0, 4'b0001);
    refill(vp(8,8,8), 16'd5, PD_, 2'd0, 1, 4'b0101);

    for (int i = 0; i < 10; i++) begin
      look(VEC[i].vpn, VEC[i].off, VEC[i].asid);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].hit, VEC[i].pa, VEC[i].perm);
    end

    @(negedge clk); fl_asid_en = 1; fl_asid = 16'd5;
    @(negedge clk); fl_asid_en = 0;
    look(vp(1,2,3), 12'h0, 16'd5);   chk("R10 asid5 4K gone", 0, 56'h0, 4'h0);
    look(vp(4,9,3), 12'h0, 16'd5);   chk("R10 asid5 2M gone", 0, 56'h0, 4'h0);
    look(vp(7,1,2), 12'h0, 16'd6);   chk("R10 asid6 kept", 1, {PC_[43:18], 9'd1, 9'd2, 12'h0}, 4'b0001);
    look(vp(8,8,8), 12'h0, 16'd5);   chk("R10 global kept", 1, {PD_, 12'h0}, 4'b0101);

    @(negedge clk); fl_all = 1;
    @(negedge clk); fl_all = 0;
    look(vp(7,1,2), 12'h0, 16'd6);   chk("R9 flush all 1G", 0, 56'h0, 4'h0);
    look(vp(8,8,8), 12'h0, 16'd5);   chk("R9 flush all global", 0, 56'h0, 4'h0);

    refill(vp(3,0,0), 16'd1, P1_, 2'd2, 0, 4'b0001);
    refill(vp(3,4,5), 16'd1, P2_, 2'd0, 0, 4'b0010);
    look(vp(3,4,5), 12'h010, 16'd1);
    chk("R11 lowest index wins", 1, {P1_[43:18], 9'd4, 9'd5, 12'h010}, 4'b0001);

    for (int k = 0; k < 6; k++)
      refill(vp(20+k,0,0), 16'd1, 44'(k+100), 2'd0, 0, 4'b0001);
    refill(vp(30,0,0), 16'd1, 44'h30, 2'd0, 0, 4'b0110);
    look(vp(3,4,5), 12'h010, 16'd1);
    chk("R8 first eviction slot0", 1, {P2_, 12'h010}, 4'b0010);
    look(vp(30,0,0), 12'h001, 16'd1);
    chk("R8 new entry hits", 1, {44'h30, 12'h001}, 4'b0110);
    refill(vp(31,0,0), 16'd1, 44'h31, 2'd0, 0, 4'b0001);
    look(vp(3,4,5), 12'h010, 16'd1);
    chk("R8 second eviction slot1", 0, 56'h0, 4'h0);
    look(vp(20,0,0), 12'h002, 16'd1);
    chk("R8 slot2 kept", 1, {44'd100, 12'h002}, 4'b0001);

    refill(vp(40,0,0), 16'd1, 44'h40, 2'd0, 0, 4'b1000, 1'b1);
    look(vp(40,0,0), 12'h003, 16'd1);
    chk("R12 refill survives flush", 1, {44'h40, 12'h003}, 4'b1000);
    look(vp(30,0,0), 12'h003, 16'd1);
    chk("R12 others flushed", 0, 56'h0, 4'h0);

    finish_run();
  end
endmodule